// File: doc/BRIEF.md
# Timed Clock-Rate and Interrupt Scheduler

This block derives a clock-enable stream for a processor tile from a fixed reference clock and delays every change to that stream until a programmed moment. A free-running wall-time counter advances once per reference cycle, whatever rate the tile currently runs at. Software issues commands that name an absolute wall time. Each command does one of three things at that time: it switches the rate level, it ends a clock hold that begins as soon as the command is taken, or it raises an interrupt.

The tile rate is set as a level k between 1 and STEPS. At level k the block passes k of every STEPS reference cycles, and it spreads those cycles evenly through a phase accumulator. Level STEPS passes every cycle. Software schedules each action at the worst-case completion time of whatever comes before it, so the tile sees the same number of cycles per time slice however long the preceding work really took. Each action kind has one pending slot. A later command of the same kind overwrites the pending one.

Top module: `tcu_top`

## Requirements
- R1: `wall_time` is 0 during reset, increases by one on every reference clock edge afterwards, and wraps modulo 2^TIME_W.
- R2: `cmd_ready` is low during reset and high from the first edge after it. A command is taken on an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_kind` 0 is a rate change, 1 is a clock hold, 2 is an interrupt, and 3 is discarded with no effect on any output.
- R3: The rate level resets to STEPS. While the clock is not held, a level of k gives exactly k `tile_ce` pulses in any STEPS consecutive cycles, so level STEPS gives a pulse on every cycle.
- R4: At any level of STEPS/2 or lower, `tile_ce` is never high on two consecutive cycles.
- R5: Let W be the value of `wall_time` in the cycle a command is taken and T its `cmd_time`. The action becomes visible in the cycle where `wall_time` reads T+1. If T−(W+1), taken as a signed TIME_W-bit value, is zero or negative, it becomes visible where `wall_time` reads W+2 instead.
- R6: `cur_level` changes only when a pending rate change fires. The level taken from `cmd_level` is clamped: 0 becomes 1, and any value above STEPS becomes STEPS.
- R7: A hold command forces `tile_ce` low from the cycle after it is taken until its release, which is timed per R5.
- R8: `irq` goes high when an interrupt fires. It stays high until the edge where `irq_ack` is sampled high, and goes low after that edge unless a new interrupt fires on the same edge.
- R9: A command taken while an action of the same kind is pending replaces that action's time (and level). The replaced action never takes effect.
- R10: Targets are compared through a signed difference. A target up to 2^(TIME_W−1)−1 cycles ahead counts as future even when the counter wraps before it is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_kind | input | 2 | 0 rate, 1 hold, 2 interrupt, 3 discard |
| cmd_time | input | TIME_W | Absolute wall time for the action |
| cmd_level | input | $clog2(STEPS+1) | Rate level for a rate command |
| irq_ack | input | 1 | Interrupt acknowledge |
| tile_ce | output | 1 | Tile clock enable |
| irq | output | 1 | Interrupt request, held until acknowledged |
| cur_level | output | $clog2(STEPS+1) | Rate level in force |
| wall_time | output | TIME_W | Wall-time counter |

## Verification
The bench builds the block with STEPS=8 and TIME_W=12. The narrow counter wraps after 4096 cycles, which brings the signed-difference comparison across the wrap within a short run (R10). Eight steps give levels whose pulse counts per window, and whose spacing at half rate or lower, can be counted directly at the output. A scoreboard holds the wall time at which each scheduled rate change, hold release and interrupt should appear. Any event that appears without an entry in it, such as one from a replaced command or a discarded kind, is reported as a failure.

// File: rtl/tcu_pkg.sv
`timescale 1ns/1ps
package tcu_pkg;
   typedef enum logic [1:0] {
      CMD_RATE  = 2'd0,
      CMD_HOLD  = 2'd1,
      CMD_ALERT = 2'd2,
      CMD_VOID  = 2'd3
   } cmd_kind_e;

   localparam int NUM_ACTIONS = 3;
   localparam int IX_RATE  = 0;
   localparam int IX_HOLD  = 1;
   localparam int IX_ALERT = 2;
endpackage

// File: rtl/tcu_walltime.sv
`timescale 1ns/1ps
module tcu_walltime #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TIME_W-1:0] now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= '0;
      else        now <= now + 1'b1;
   end
endmodule

// File: rtl/tcu_slot.sv
`timescale 1ns/1ps
module tcu_slot #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_time,
   input  logic [TIME_W-1:0] now,
   output logic              fire
);
   logic              pending;
   logic [TIME_W-1:0] target;
   logic [TIME_W-1:0] gap;
   logic              due;

   // signed distance to target; zero or negative means due
   assign gap  = target - now;
   assign due  = pending && (gap[TIME_W-1] || (gap == '0));
   // a fresh load of the same kind supersedes a due action
   assign fire = due && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         target  <= '0;
      end else if (load) begin
         pending <= 1'b1;
         target  <= load_time;
      end else if (due) begin
         pending <= 1'b0;
      end
   end
endmodule

// File: rtl/tcu_divider.sv
`timescale 1ns/1ps
module tcu_divider #(
   parameter  int STEPS = 8,
   localparam int PH_W  = $clog2(STEPS),
   localparam int LVL_W = $clog2(STEPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   output logic             ce
);
   logic [PH_W-1:0]  acc;
   logic [LVL_W-1:0] sum;

   assign sum = LVL_W'(acc) + level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         ce  <= 1'b0;
      end else begin
         acc <= sum[PH_W-1:0];
         ce  <= sum[PH_W];
      end
   end
endmodule

// File: rtl/tcu_top.sv
`timescale 1ns/1ps
module tcu_top
   import tcu_pkg::*;
#(
   parameter  int TIME_W = 32,
   parameter  int STEPS  = 8,
   localparam int LVL_W  = $clog2(STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_kind,
   input  logic [TIME_W-1:0] cmd_time,
   input  logic [LVL_W-1:0]  cmd_level,
   input  logic              irq_ack,
   output logic              tile_ce,
   output logic              irq,
   output logic [LVL_W-1:0]  cur_level,
   output logic [TIME_W-1:0] wall_time
);
   generate
      if (STEPS < 2 || (STEPS & (STEPS - 1)) != 0) begin : g_bad_steps
         $error("tcu_top: STEPS must be a power of two, at least 2");
      end
      if (TIME_W < 4) begin : g_bad_time
         $error("tcu_top: TIME_W must be at least 4");
      end
   endgenerate

   function automatic logic [LVL_W-1:0] clamp_level(input logic [LVL_W-1:0] v);
      if (v == '0)               return LVL_W'(1);
      if (v > LVL_W'(STEPS))     return LVL_W'(STEPS);
      return v;
   endfunction

   logic                   rdy_q;
   logic                   accept;
   logic [NUM_ACTIONS-1:0] load;
   logic [NUM_ACTIONS-1:0] fire;
   logic [LVL_W-1:0]       rate_next;
   logic [LVL_W-1:0]       level_q;
   logic                   hold_q;
   logic                   alert_q;
   logic                   div_ce;
   logic                   fire_rate;
   logic                   fire_alert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_q <= 1'b0;
      else        rdy_q <= 1'b1;
   end

   assign cmd_ready = rdy_q;
   assign accept    = cmd_valid && rdy_q;

   tcu_walltime #(.TIME_W(TIME_W)) u_wall (
      .clk   (clk),
      .rst_n (rst_n),
      .now   (wall_time)
   );

   generate
      for (genvar k = 0; k < NUM_ACTIONS; k++) begin : g_slot
         assign load[k] = accept && (cmd_kind == 2'(k));
         tcu_slot #(.TIME_W(TIME_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load[k]),
            .load_time (cmd_time),
            .now       (wall_time),
            .fire      (fire[k])
         );
      end
   endgenerate

   assign fire_rate  = fire[IX_RATE];
   assign fire_alert = fire[IX_ALERT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_next <= LVL_W'(STEPS);
         level_q   <= LVL_W'(STEPS);
         hold_q    <= 1'b0;
         alert_q   <= 1'b0;
      end else begin
         if (load[IX_RATE])       rate_next <= clamp_level(cmd_level);
         if (fire_rate)           level_q   <= rate_next;
         if (load[IX_HOLD])       hold_q    <= 1'b1;
         else if (fire[IX_HOLD])  hold_q    <= 1'b0;
         if (fire_alert)          alert_q   <= 1'b1;
         else if (irq_ack)        alert_q   <= 1'b0;
      end
   end

   tcu_divider #(.STEPS(STEPS)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .level (level_q),
      .ce    (div_ce)
   );

   assign tile_ce   = div_ce && !hold_q;
   assign irq       = alert_q;
   assign cur_level = level_q;
endmodule

// File: rtl/tcu_checker.sv
`timescale 1ns/1ps
module tcu_checker #(
   parameter  int TIME_W = 32,
   parameter  int STEPS  = 8,
   localparam int LVL_W  = $clog2(STEPS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_kind,
   input logic              irq_ack,
   input logic              tile_ce,
   input logic              irq,
   input logic [LVL_W-1:0]  cur_level,
   input logic [TIME_W-1:0] wall_time,
   input logic              fire_rate,
   input logic              fire_alert,
   input logic              hold_on
);
   logic [1:0] armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             armed <= '0;
      else if (armed != 2'd3) armed <= armed + 2'd1;
   end

   p_wall_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed != 2'd0) |-> (wall_time == TIME_W'($past(wall_time) + 1'b1)));

   p_ready_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed != 2'd0) |-> cmd_ready);

   p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed == 2'd3 && $past(cur_level) == LVL_W'(STEPS)
       && $past(cur_level, 2) == LVL_W'(STEPS)) |-> (tile_ce || hold_on));

   p_level_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level >= LVL_W'(1)) && (cur_level <= LVL_W'(STEPS)));

   p_level_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed != 2'd0 && !$stable(cur_level)) |-> $past(fire_rate));

   p_hold_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_kind == 2'd1) |=> !tile_ce);

   p_irq_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   p_irq_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && irq_ack && !fire_alert) |=> !irq);
endmodule

bind tcu_top tcu_checker #(.TIME_W(TIME_W), .STEPS(STEPS)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_kind   (cmd_kind),
   .irq_ack    (irq_ack),
   .tile_ce    (tile_ce),
   .irq        (irq),
   .cur_level  (cur_level),
   .wall_time  (wall_time),
   .fire_rate  (fire_rate),
   .fire_alert (fire_alert),
   .hold_on    (hold_q)
);

// File: tb/tb_tcu_top.sv
`timescale 1ns/1ps
module tb_tcu_top;
   localparam int TW = 12;
   localparam int ST = 8;
   localparam int LW = $clog2(ST + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [1:0]    cmd_kind = '0;
   logic [TW-1:0] cmd_time = '0;
   logic [LW-1:0] cmd_level = '0;
   logic          irq_ack = 1'b0;
   logic          tile_ce;
   logic          irq;
   logic [LW-1:0] cur_level;
   logic [TW-1:0] wall_time;

   always #2 clk = ~clk;

   tcu_top #(.TIME_W(TW), .STEPS(ST)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_kind(cmd_kind), .cmd_time(cmd_time), .cmd_level(cmd_level),
      .irq_ack(irq_ack), .tile_ce(tile_ce), .irq(irq),
      .cur_level(cur_level), .wall_time(wall_time)
   );

   typedef struct {
      int    kind;
      int    at;
      int    val;
      string req;
   } ev_t;

   ev_t   expq[$];
   int    total = 0;
   int    bad = 0;
   bit    mon_on = 1'b0;
   bit    gate_watch = 1'b0;
   logic [LW-1:0] prev_lvl = '0;
   logic  prev_irq = 1'b0;
   logic  prev_ce = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // monitor: pops expected events as the design produces them
   task automatic seen(input int kind, input int val);
      ev_t e;
      if (expq.size() == 0) begin
         chk(1'b0, "R9", "unexpected event kind", kind, -1);
      end else begin
         e = expq.pop_front();
         chk(e.kind == kind, e.req, "event kind", kind, e.kind);
         chk(e.at == int'(wall_time), e.req, "event wall time", int'(wall_time), e.at);
         chk(e.val == val, e.req, "event value", val, e.val);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         if (cur_level != prev_lvl) seen(0, int'(cur_level));
         if (irq && !prev_irq) seen(2, 0);
         if (gate_watch && tile_ce && !prev_ce) begin
            gate_watch = 1'b0;
            seen(1, 0);
         end
      end
      prev_lvl = cur_level;
      prev_irq = irq;
      prev_ce  = tile_ce;
   end

   // driver: issues a command rel cycles ahead and records its expected effect
   task automatic send(input int kind, input int rel, input int lvl,
                       input bit expect_it, input int eval, input string req);
      logic [TW-1:0] w, tt, dd;
      ev_t e;
      @(negedge clk);
      w         = wall_time;
      tt        = TW'(int'(w) + rel);
      cmd_valid = 1'b1;
      cmd_kind  = 2'(kind);
      cmd_time  = tt;
      cmd_level = LW'(lvl);
      @(posedge clk);
      #1 cmd_valid = 1'b0;
      if (kind == 1) gate_watch = 1'b1;
      if (expect_it) begin
         dd = tt - (w + 1'b1);
         e.kind = kind;
         e.at   = (dd[TW-1] || dd == '0) ? int'(TW'(w + 2'd2)) : int'(TW'(tt + 1'b1));
         e.val  = eval;
         e.req  = req;
         expq.push_back(e);
      end
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < 300 && expq.size() != 0; i++) @(negedge clk);
      chk(expq.size() == 0, req, "events still pending", expq.size(), 0);
   endtask

   task automatic window(input int lvl, input string req);
      int c = 0;
      repeat (ST) begin
         @(negedge clk);
         c += int'(tile_ce);
      end
      chk(c == lvl, req, "enables per window", c, lvl);
   endtask

   task automatic no_pairs();
      int pairs = 0;
      bit p = 1'b0;
      repeat (2 * ST) begin
         @(negedge clk);
         if (tile_ce && p) pairs++;
         p = tile_ce;
      end
      chk(pairs == 0, "R4", "back-to-back enables", pairs, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
   end

   initial begin
      int w0;
      int ones;
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b0, "R2", "ready in reset", int'(cmd_ready), 0);
      chk(wall_time == '0, "R1", "wall time in reset", int'(wall_time), 0);
      chk(cur_level == LW'(ST), "R3", "level after reset", int'(cur_level), ST);
      chk(irq == 1'b0, "R8", "irq in reset", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R2", "ready after reset", int'(cmd_ready), 1);
      chk(wall_time == TW'(1), "R1", "wall time after first edge", int'(wall_time), 1);
      mon_on = 1'b1;

      w0 = int'(wall_time);
      repeat (10) @(negedge clk);
      chk(int'(wall_time) == w0 + 10, "R1", "wall advance", int'(wall_time), w0 + 10);
      window(8, "R3");

      // rate changes and pulse spreading
      send(0, 20, 4, 1, 4, "R5");
      drain("R5");
      repeat (3) @(negedge clk);
      window(4, "R3");
      no_pairs();
      send(0, 10, 3, 1, 3, "R6");
      drain("R6");
      repeat (3) @(negedge clk);
      window(3, "R3");
      no_pairs();
      send(0, 7, 1, 1, 1, "R6");
      drain("R6");
      repeat (3) @(negedge clk);
      window(1, "R3");
      send(0, 9, 5, 1, 5, "R6");
      drain("R6");
      repeat (3) @(negedge clk);
      window(5, "R3");

      // clamping of level field
      send(0, 6, 0, 1, 1, "R6");
      drain("R6");
      send(0, 6, 15, 1, 8, "R6");
      drain("R6");

      // target already past
      send(0, -5, 6, 1, 6, "R5");
      drain("R5");

      // replacement of a pending rate change
      send(0, 30, 2, 0, 0, "R9");
      send(0, 40, 3, 1, 3, "R9");
      drain("R9");

      send(0, 5, 8, 1, 8, "R6");
      drain("R6");
      repeat (3) @(negedge clk);
      window(8, "R3");

      // clock hold
      send(1, 25, 0, 1, 0, "R7");
      @(negedge clk);
      chk(tile_ce == 1'b0, "R7", "enable right after hold", int'(tile_ce), 0);
      drain("R7");

      // interrupt, held until acknowledge
      send(2, 15, 0, 1, 0, "R8");
      drain("R8");
      ones = 0;
      repeat (10) begin
         @(negedge clk);
         ones += int'(irq);
      end
      chk(ones == 10, "R8", "irq held cycles", ones, 10);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(irq == 1'b0, "R8", "irq after ack", int'(irq), 0);

      // interrupt replaced by a sooner one
      send(2, 60, 0, 0, 0, "R9");
      send(2, 12, 0, 1, 0, "R9");
      drain("R9");
      repeat (70) @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(irq == 1'b0, "R9", "no second irq from replaced one", int'(irq), 0);

      // discarded kind
      send(3, 10, 2, 0, 0, "R2");
      repeat (40) @(negedge clk);
      chk(cur_level == LW'(ST), "R2", "level after discarded kind", int'(cur_level), ST);
      chk(irq == 1'b0, "R2", "irq after discarded kind", int'(irq), 0);

      // target across the counter wrap
      while (wall_time != TW'(4080)) @(negedge clk);
      send(2, 20, 0, 1, 0, "R10");
      @(negedge clk);
      chk(irq == 1'b0, "R10", "irq early before wrap", int'(irq), 0);
      drain("R10");
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;

      mon_on = 1'b0;
      summary();
   end
endmodule